// File: doc/BRIEF.md
# Dual-Rail Power Mode Sequencer

This block is the mode controller for a memory power supply with two switching rails, a main supply rail and a tracking termination rail, plus a buffered reference output. Two active-low control pins choose between normal operation, a low-power standby and a full shutdown. An input-supply-valid flag overrides both pins and forces everything off. The block drives the rail enables, the discharge switches, the high-impedance control of the termination rail and the soft-start start strobes. It also drives an active-low power-good output.

Both control pins go through a two-flop synchronizer and are then decoded into a mode. Each time a rail is brought up, the block starts a soft-start timer for that rail. This happens on power-up, when leaving standby or shutdown, and when a channel's fault flag clears (a fault retry). The main rail's soft-start time comes from a 2-bit code that is latched when the mode changes. The termination rail always uses a fixed time. Power-good asserts only after a further delay, counted once both soft-starts have finished and both rails are in regulation with no fault. The count restarts from zero whenever that qualification drops. Durations are given in clock cycles: `SS_BASE_CYC` is the shortest main-rail soft-start time and `PG_DELAY_CYC` is the power-good delay.

Top module: `ddr_rail_sequencer`

## Requirements
- R1: Pin changes reach the outputs on the third rising clock edge after the change. With the supply valid, shutdown_n low selects shutdown whatever standby_n is. shutdown_n high with standby_n low selects standby. Both pins high select normal.
- R2: In standby, main_en and ref_en are 1, term_en is 0, term_hiz is 1, all discharge outputs are 0 and pwr_good_n is 1.
- R3: In shutdown, every enable and term_hiz are 0 and all three discharge outputs are 1. No discharge output is ever 1 outside shutdown.
- R4: When supply_ok is 0, the outputs at the next rising edge have every enable, term_hiz and every discharge output at 0, and pwr_good_n at 1. When supply_ok returns with both pins high, the rails come back in normal mode with new soft-starts.
- R5: Entering normal from any other mode pulses ss_go_main and ss_go_term high for one cycle. Entering standby from off or shutdown pulses only ss_go_main. Going from normal to standby pulses neither.
- R6: The main soft-start lasts SS_BASE_CYC << (3 - code) cycles: code 0 gives 8x, 1 gives 4x, 2 gives 2x and 3 gives 1x the base. The termination soft-start always lasts 4x the base.
- R7: After a soft-start strobe edge S, with both in-regulation flags high and no fault, pwr_good_n falls at edge S + D + PG_DELAY_CYC + 1. D is the longest soft-start still running.
- R8: pwr_good_n goes high at the first rising edge after either fault flag is seen high. It is high during reset and in the off, shutdown and standby modes.
- R9: In normal mode, a falling edge on a channel's fault flag restarts only that channel's soft-start and pulses only that channel's strobe. Power-good then follows R7 from that strobe.
- R10: The soft-start code is latched only on a mode change that strobes the main rail. A fault retry uses the held code even if ss_code has since changed.
- R11: If an in-regulation flag drops while the power-good delay is counting, or after power-good has asserted, pwr_good_n goes high and the full delay is counted again from zero once the flag returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shutdown_n | input | 1 | Asynchronous active-low shutdown request |
| standby_n | input | 1 | Asynchronous active-low standby request |
| supply_ok | input | 1 | Input supply within its valid range |
| fault_main | input | 1 | Main-rail channel fault from its protection controller |
| fault_term | input | 1 | Termination-rail channel fault from its protection controller |
| inreg_main | input | 1 | Main rail within regulation window |
| inreg_term | input | 1 | Termination rail within regulation window |
| ss_code | input | 2 | Main-rail soft-start duration select |
| main_en | output | 1 | Main rail enable |
| term_en | output | 1 | Termination rail enable |
| ref_en | output | 1 | Reference buffer enable |
| term_hiz | output | 1 | Termination rail high-impedance |
| dis_main | output | 1 | Main rail discharge switch |
| dis_term | output | 1 | Termination rail discharge switch |
| dis_ref | output | 1 | Reference discharge switch |
| ss_go_main | output | 1 | One-cycle main soft-start start strobe |
| ss_go_term | output | 1 | One-cycle termination soft-start start strobe |
| pwr_good_n | output | 1 | Active-low power-good |

## Verification
The hardest case to reach is the held soft-start code. It only shows up when a fault retry follows a mode exit and ss_code has changed in between. The bench therefore sweeps all four codes. For each code it exits shutdown, changes ss_code, pulses the main fault, and times power-good from the retry strobe. The restart of the power-good count is reached the same way: in-regulation is dropped for one cycle while the count is partly done, and the full delay is then expected from the moment it returns.

// File: rtl/rseq_pkg.sv
package rseq_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_SHDN = 2'd1,
    MODE_STBY = 2'd2,
    MODE_NORM = 2'd3
  } rail_mode_e;

  typedef struct packed {
    logic main_en;
    logic term_en;
    logic ref_en;
    logic term_hiz;
    logic dis_main;
    logic dis_term;
    logic dis_ref;
  } rail_ctl_t;

  localparam int NCH          = 2;
  localparam int CH_MAIN      = 0;
  localparam int CH_TERM      = 1;
  localparam int SS_CODE_W    = 2;
  localparam int SS_SHIFT_MAX = 3;
  localparam int TERM_SHIFT   = 2;

  // Shutdown wins over standby; an invalid supply wins over both.
  function automatic rail_mode_e decode_mode(input logic vin_good,
                                             input logic sd_n_s,
                                             input logic stby_n_s);
    rail_mode_e m;
    if (!vin_good)      m = MODE_OFF;
    else if (!sd_n_s)   m = MODE_SHDN;
    else if (!stby_n_s) m = MODE_STBY;
    else                m = MODE_NORM;
    return m;
  endfunction

  function automatic rail_ctl_t ctl_for_mode(input rail_mode_e m);
    rail_ctl_t c;
    c = '0;
    case (m)
      MODE_SHDN: begin
        c.dis_main = 1'b1;
        c.dis_term = 1'b1;
        c.dis_ref  = 1'b1;
      end
      MODE_STBY: begin
        c.main_en  = 1'b1;
        c.ref_en   = 1'b1;
        c.term_hiz = 1'b1;
      end
      MODE_NORM: begin
        c.main_en = 1'b1;
        c.term_en = 1'b1;
        c.ref_en  = 1'b1;
      end
      default: c = '0;
    endcase
    return c;
  endfunction

  function automatic logic main_live(input rail_mode_e m);
    return (m == MODE_STBY) || (m == MODE_NORM);
  endfunction

endpackage

// File: rtl/rseq_sync.sv
module rseq_sync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage[g] <= RESET_VAL;
        else     stage[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage[g] <= RESET_VAL;
        else     stage[g] <= stage[g-1];
      end
    end
  end

  assign q = stage[STAGES-1];

endmodule

// File: rtl/rseq_ss_timer.sv
module rseq_ss_timer #(
  parameter int BASE_CYC = 40000,
  parameter int MAX_SHIFT = 3,
  localparam int SW = (MAX_SHIFT < 1) ? 1 : $clog2(MAX_SHIFT + 1),
  localparam int CW = $clog2((BASE_CYC << MAX_SHIFT) + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [SW-1:0] shift,
  output logic          busy
);

  localparam logic [CW-1:0] BASE_W = CW'(BASE_CYC);

  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
    end else if (start) begin
      remain <= BASE_W << shift;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign busy = (remain != '0);

endmodule

// File: rtl/rseq_pg_delay.sv
module rseq_pg_delay #(
  parameter int DELAY_CYC = 1000000,
  localparam int CW = $clog2(DELAY_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic qualify,
  output logic pg_n
);

  localparam logic [CW-1:0] LIMIT = CW'(DELAY_CYC);

  logic [CW-1:0] elapsed;

  always_ff @(posedge clk) begin
    if (rst) begin
      elapsed <= '0;
      pg_n    <= 1'b1;
    end else if (!qualify) begin
      elapsed <= '0;
      pg_n    <= 1'b1;
    end else if (elapsed == LIMIT) begin
      pg_n <= 1'b0;
    end else begin
      elapsed <= elapsed + 1'b1;
    end
  end

endmodule

// File: rtl/ddr_rail_sequencer.sv
module ddr_rail_sequencer
  import rseq_pkg::*;
#(
  parameter int SS_BASE_CYC  = 40000,
  parameter int PG_DELAY_CYC = 1000000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 shutdown_n,
  input  logic                 standby_n,
  input  logic                 supply_ok,
  input  logic                 fault_main,
  input  logic                 fault_term,
  input  logic                 inreg_main,
  input  logic                 inreg_term,
  input  logic [SS_CODE_W-1:0] ss_code,
  output logic                 main_en,
  output logic                 term_en,
  output logic                 ref_en,
  output logic                 term_hiz,
  output logic                 dis_main,
  output logic                 dis_term,
  output logic                 dis_ref,
  output logic                 ss_go_main,
  output logic                 ss_go_term,
  output logic                 pwr_good_n
);

  localparam int SHW = $clog2(SS_SHIFT_MAX + 1);

  // Pin synchronizer: resets to "shutdown" so nothing drives before the pins settle.
  logic [1:0] pins_s;

  rseq_sync #(
    .WIDTH    (2),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(2'b00)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  ({shutdown_n, standby_n}),
    .q  (pins_s)
  );

  rail_mode_e mode_q, mode_next;
  rail_ctl_t  ctl_q;
  logic [NCH-1:0] fault_vec, fault_q;
  logic [NCH-1:0] live_next, retry_c, start_c, busy;
  logic [NCH-1:0] go_q;
  logic [SS_CODE_W-1:0] code_q, code_eff;
  logic [SHW-1:0] shift_c [NCH];
  logic enter_norm, wake_main, latch_code, qualify;

  assign mode_next = decode_mode(supply_ok, pins_s[1], pins_s[0]);
  assign fault_vec = {fault_term, fault_main};

  assign live_next[CH_MAIN] = main_live(mode_next);
  assign live_next[CH_TERM] = (mode_next == MODE_NORM);

  assign enter_norm = (mode_next == MODE_NORM) && (mode_q != MODE_NORM);
  assign wake_main  = main_live(mode_next) && !main_live(mode_q);

  // Fault retry: the channel's fault flag falls while the mode is unchanged.
  for (genvar ch = 0; ch < NCH; ch++) begin : g_retry
    assign retry_c[ch] = (mode_next == mode_q) && live_next[ch] &&
                         fault_q[ch] && !fault_vec[ch];
  end

  assign start_c[CH_MAIN] = enter_norm || wake_main || retry_c[CH_MAIN];
  assign start_c[CH_TERM] = enter_norm || retry_c[CH_TERM];

  // Code is captured on a mode exit only; retries reuse the held value.
  assign latch_code = (mode_next != mode_q) && start_c[CH_MAIN];
  assign code_eff   = latch_code ? ss_code : code_q;

  assign shift_c[CH_MAIN] = SHW'(SS_SHIFT_MAX) - SHW'(code_eff);
  assign shift_c[CH_TERM] = SHW'(TERM_SHIFT);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ss
    rseq_ss_timer #(
      .BASE_CYC (SS_BASE_CYC),
      .MAX_SHIFT(SS_SHIFT_MAX)
    ) u_timer (
      .clk  (clk),
      .rst  (rst),
      .start(start_c[ch]),
      .shift(shift_c[ch]),
      .busy (busy[ch])
    );
  end

  assign qualify = (mode_next == MODE_NORM) && (start_c == '0) &&
                   (busy == '0) && (fault_vec == '0) &&
                   inreg_main && inreg_term;

  rseq_pg_delay #(
    .DELAY_CYC(PG_DELAY_CYC)
  ) u_pg (
    .clk    (clk),
    .rst    (rst),
    .qualify(qualify),
    .pg_n   (pwr_good_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_OFF;
      ctl_q   <= '0;
      go_q    <= '0;
      fault_q <= '0;
      code_q  <= '0;
    end else begin
      mode_q  <= mode_next;
      ctl_q   <= ctl_for_mode(mode_next);
      go_q    <= start_c;
      fault_q <= fault_vec;
      if (latch_code) code_q <= ss_code;
    end
  end

  assign main_en    = ctl_q.main_en;
  assign term_en    = ctl_q.term_en;
  assign ref_en     = ctl_q.ref_en;
  assign term_hiz   = ctl_q.term_hiz;
  assign dis_main   = ctl_q.dis_main;
  assign dis_term   = ctl_q.dis_term;
  assign dis_ref    = ctl_q.dis_ref;
  assign ss_go_main = go_q[CH_MAIN];
  assign ss_go_term = go_q[CH_TERM];

endmodule

// File: rtl/rseq_checker.sv
module rseq_checker (
  input logic clk,
  input logic rst,
  input logic shutdown_n,
  input logic supply_ok,
  input logic fault_main,
  input logic fault_term,
  input logic inreg_main,
  input logic inreg_term,
  input logic main_en,
  input logic term_en,
  input logic ref_en,
  input logic term_hiz,
  input logic dis_main,
  input logic dis_term,
  input logic dis_ref,
  input logic ss_go_main,
  input logic ss_go_term,
  input logic pwr_good_n
);

  logic [2:0] settle;

  always_ff @(posedge clk) begin
    if (rst) settle <= '0;
    else if (settle != 3'd7) settle <= settle + 1'b1;
  end

  assert_shdn_decode_R1: assert property (@(posedge clk) disable iff (rst)
    (settle >= 3'd4 && !$past(shutdown_n, 3) && $past(supply_ok)) |-> dis_main);

  assert_stby_outputs_R2: assert property (@(posedge clk) disable iff (rst)
    term_hiz |-> (main_en && ref_en && !term_en && !dis_main && pwr_good_n));

  assert_discharge_only_shdn_R3: assert property (@(posedge clk) disable iff (rst)
    dis_main |-> (dis_term && dis_ref && !main_en && !term_en && !ref_en && !term_hiz));

  assert_supply_off_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(supply_ok) |-> (!main_en && !term_en && !ref_en && !term_hiz &&
                           !dis_main && !dis_term && !dis_ref && pwr_good_n));

  assert_strobe_enabled_R5: assert property (@(posedge clk) disable iff (rst)
    ss_go_term |-> (term_en && main_en && ss_go_main || term_en && main_en && !ss_go_main));

  assert_main_strobe_enabled_R5: assert property (@(posedge clk) disable iff (rst)
    ss_go_main |-> main_en);

  assert_pg_qualified_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(pwr_good_n) |-> $past(inreg_main && inreg_term && !fault_main && !fault_term));

  assert_fault_drops_pg_R8: assert property (@(posedge clk) disable iff (rst)
    $past(fault_main || fault_term) |-> pwr_good_n);

  assert_pg_normal_only_R8: assert property (@(posedge clk) disable iff (rst)
    !pwr_good_n |-> (main_en && term_en && ref_en && !term_hiz));

endmodule

bind ddr_rail_sequencer rseq_checker u_chk (.*);

// File: tb/ddr_rail_sequencer_test.sv
module ddr_rail_sequencer_test;

  localparam int B = 3;
  localparam int P = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic shutdown_n = 1'b0, standby_n = 1'b1, supply_ok = 1'b1;
  logic fault_main = 1'b0, fault_term = 1'b0;
  logic inreg_main = 1'b1, inreg_term = 1'b1;
  logic [1:0] ss_code = 2'd0;
  logic main_en, term_en, ref_en, term_hiz, dis_main, dis_term, dis_ref;
  logic ss_go_main, ss_go_term, pwr_good_n;

  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  ddr_rail_sequencer #(
    .SS_BASE_CYC (B),
    .PG_DELAY_CYC(P)
  ) uut (.*);

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int main_dur(input int code);
    return B << (3 - code);
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Count negedges until power-good is seen low; called at the strobe negedge.
  task automatic measure_pg(output int n);
    n = 0;
    while (pwr_good_n && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic wait_strobe();
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (ss_go_main || ss_go_term) break;
    end
  endtask

  task automatic chk_shdn(input string tag);
    chk(tag, "shutdown discharge", {dis_main, dis_term, dis_ref}, 3'b111);
    chk(tag, "shutdown enables", {main_en, term_en, ref_en, term_hiz}, 4'b0000);
  endtask

  int n;

  initial begin
    step(3);
    // Reset state
    chk("R8", "reset outputs", {main_en, term_en, ref_en, term_hiz, dis_main,
        dis_term, dis_ref, ss_go_main, ss_go_term}, 0);
    chk("R8", "reset pg_n", pwr_good_n, 1);
    rst = 1'b0;
    step(5);
    chk_shdn("R3");

    // R1 latency: pins high take effect on the third edge
    shutdown_n = 1'b1;
    step(2);
    chk("R1", "still shutdown after two edges", dis_main, 1);
    step(1);
    chk("R1", "normal after third edge", {main_en, term_en, ref_en, dis_main}, 4'b1110);
    chk("R5", "both strobes entering normal", {ss_go_main, ss_go_term}, 2'b11);
    measure_pg(n);
    chk("R7", "pg delay code0 power-up", n, imax(main_dur(0), 4 * B) + P + 1);

    for (int c = 0; c < 4; c++) begin
      shutdown_n = 1'b0;
      step(4);
      chk_shdn("R3");
      chk("R8", "pg high in shutdown", pwr_good_n, 1);
      ss_code = 2'(c);
      shutdown_n = 1'b1;
      wait_strobe();
      chk("R5", "strobes after shutdown exit", {ss_go_main, ss_go_term}, 2'b11);
      measure_pg(n);
      chk("R7", $sformatf("pg delay code %0d", c), n, imax(main_dur(c), 4 * B) + P + 1);
      // R10: change the code, then a retry must still use the latched one
      ss_code = ~2'(c);
      fault_main = 1'b1;
      step(1);
      chk("R8", "pg high after main fault", pwr_good_n, 1);
      step(1);
      fault_main = 1'b0;
      step(1);
      chk("R9", "main-only strobe on retry", {ss_go_main, ss_go_term}, 2'b10);
      measure_pg(n);
      chk("R6", $sformatf("main retry duration code %0d (R10 held)", c), n, main_dur(c) + P + 1);
    end

    // Termination retry
    fault_term = 1'b1;
    step(1);
    chk("R8", "pg high after term fault", pwr_good_n, 1);
    step(1);
    fault_term = 1'b0;
    step(1);
    chk("R9", "term-only strobe on retry", {ss_go_main, ss_go_term}, 2'b01);
    measure_pg(n);
    chk("R6", "term retry duration", n, 4 * B + P + 1);

    // R11: in-regulation drop after power-good
    inreg_term = 1'b0;
    step(1);
    chk("R11", "pg high on inreg drop", pwr_good_n, 1);
    inreg_term = 1'b1;
    measure_pg(n);
    chk("R11", "full delay after inreg returns", n, P + 1);

    // R11: drop in the middle of the count
    fault_main = 1'b1;
    step(2);
    fault_main = 1'b0;
    step(1);
    chk("R9", "retry strobe before mid-count drop", ss_go_main, 1);
    step(main_dur(3) + 4);
    chk("R11", "still counting", pwr_good_n, 1);
    inreg_main = 1'b0;
    step(1);
    inreg_main = 1'b1;
    measure_pg(n);
    chk("R11", "count restarts from zero", n, P + 1);

    // Standby from normal
    standby_n = 1'b0;
    step(3);
    chk("R2", "standby outputs", {main_en, term_en, ref_en, term_hiz}, 4'b1011);
    chk("R2", "standby discharge", {dis_main, dis_term, dis_ref}, 3'b000);
    chk("R8", "pg high in standby", pwr_good_n, 1);
    chk("R5", "no strobe normal to standby", {ss_go_main, ss_go_term}, 2'b00);

    // Shutdown overrides standby
    shutdown_n = 1'b0;
    step(3);
    chk_shdn("R1");

    // Shutdown to standby: main strobe only
    shutdown_n = 1'b1;
    step(3);
    chk("R5", "main-only strobe entering standby", {ss_go_main, ss_go_term}, 2'b10);
    chk("R2", "term hiz in standby", term_hiz, 1);

    // Standby to normal
    ss_code = 2'd2;
    standby_n = 1'b1;
    step(3);
    chk("R5", "both strobes leaving standby", {ss_go_main, ss_go_term}, 2'b11);
    chk("R1", "normal after standby exit", {term_en, term_hiz}, 2'b10);
    measure_pg(n);
    chk("R7", "pg delay after standby exit code2", n, imax(main_dur(2), 4 * B) + P + 1);

    // Supply invalid
    supply_ok = 1'b0;
    step(1);
    chk("R4", "all off with supply invalid", {main_en, term_en, ref_en, term_hiz,
        dis_main, dis_term, dis_ref}, 0);
    chk("R4", "pg high with supply invalid", pwr_good_n, 1);
    supply_ok = 1'b1;
    step(1);
    chk("R4", "supply return restarts rails", {main_en, term_en, ss_go_main, ss_go_term}, 4'b1111);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule